// File: doc/BRIEF.md
# Link Encryption Stream State Controller

This block tracks the security state of a small set of encrypted link streams, each placed between a transaction layer and a data link layer. Every stream starts out insecure. Software loads key material into one of two key-set slots per stream, which raises that slot's valid flag. It then writes the stream's enable bit. The stream becomes secure only if the key set it would start on is valid. While secure, software may flip the stream to its other key set. Every flip retires the set that was left, so that set must be reloaded before it can be selected again.

The block also screens incoming packet prefixes. A prefix whose type byte marks it as encrypted traffic names a stream and a key set. If the named stream is secure and the selected key set is valid, the block reports a hit together with the decoded stream and key. Otherwise it raises a one-cycle error pulse and drops the named stream back to insecure. The cryptographic engine, key exchange and data path are outside this block.

Top module: `link_sec_ctrl`

## Requirements
- R1: After reset, every stream is insecure, its active key index is 0, both of its key valid flags are 0, and err_o and pfx_hit_o are 0.
- R2: A key load strobe for stream s and slot k sets the valid flag of that slot, and the flag is visible after the sampling edge.
- R3: A control write whose bit 0 is 1, made to an insecure stream whose slot 0 is valid, makes that stream secure after the edge. Bits 7:1 of the control data are ignored.
- R4: A control write with bit 0 set to an insecure stream whose slot 0 is not valid leaves the stream insecure and raises err_o for one cycle.
- R5: A control write with bit 0 clear makes the stream insecure after the edge, with active key index 0. If the stream was secure, both of its valid flags are cleared.
- R6: A key switch request to a secure stream whose other slot is valid toggles the active key index and clears the valid flag of the slot that was left.
- R7: A key switch request to a stream that is insecure, or whose other slot is not valid, changes no status output.
- R8: A prefix with bits 31:24 equal to 0x92 is checked. Bits 7:0 give the stream ID and bit 13 gives the key set. If the stream is secure and that key set is valid, pfx_hit_o pulses one cycle later, carrying that stream ID on pfx_sid_o and that key set on pfx_key_o.
- R9: A checked prefix whose stream ID is out of range (8 or more), whose stream is insecure, or whose key set is invalid raises err_o one cycle later and no hit. A secure stream named this way becomes insecure, with active index 0 and both valid flags cleared.
- R10: A prefix whose bits 31:24 differ from 0x92 causes no hit, no error and no state change.
- R11: err_o falls back to 0 in the cycle after an error when no new error event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_sid_i | input | SID_W | Stream addressed by the control write |
| ctrl_wdata_i | input | 8 | Control data; bit 0 is enable |
| key_ld_i | input | 1 | Key load strobe |
| key_sid_i | input | SID_W | Stream addressed by the key load |
| key_slot_i | input | 1 | Key-set slot being loaded |
| ksw_i | input | 1 | Key switch request |
| ksw_sid_i | input | SID_W | Stream addressed by the key switch |
| pfx_vld_i | input | 1 | Prefix present this cycle |
| pfx_i | input | 32 | Prefix dword |
| pfx_hit_o | output | 1 | Accepted prefix pulse |
| pfx_sid_o | output | SID_W | Stream of the accepted prefix |
| pfx_key_o | output | 1 | Key set of the accepted prefix |
| err_o | output | 1 | One-cycle error pulse |
| secure_o | output | NUM_STREAMS | Per-stream secure state |
| key_act_o | output | NUM_STREAMS | Per-stream active key-set index |
| key_vld0_o | output | NUM_STREAMS | Per-stream slot 0 valid flag |
| key_vld1_o | output | NUM_STREAMS | Per-stream slot 1 valid flag |

## Verification
Every result is due exactly one clock edge after its stimulus is sampled: status flags, err_o and the prefix hit fields are all registers, with no extra stage. The bench applies each stimulus after a falling edge and keeps it for one rising edge. It then removes the stimulus and compares all outputs 1 ns after that rising edge against a per-stream model, so each check sees the result of exactly one operation. Error pulse width is checked with an idle cycle after each error, and every operation compares the status of all eight streams, so that a change leaking into a stream that was not addressed is caught.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int          CTRL_W       = 8;
  localparam int          PFX_W        = 32;
  localparam int          PFX_SID_W    = 8;
  localparam int          PFX_K_BIT    = 13;
  localparam int          PFX_TYPE_LSB = 24;
  localparam logic [7:0]  PFX_TYPE     = 8'h92;

  typedef enum logic {ST_INSEC = 1'b0, ST_SEC = 1'b1} sec_st_e;

  typedef struct packed {
    logic                 match;
    logic [PFX_SID_W-1:0] sid;
    logic                 k;
  } pfx_fields_t;
endpackage

// File: rtl/lsc_pfx_dec.sv
module lsc_pfx_dec
  import lsc_pkg::*;
(
  input  logic             pfx_vld_i,
  input  logic [PFX_W-1:0] pfx_i,
  output pfx_fields_t      fld_o
);
  logic unused_pfx_bits;
  assign unused_pfx_bits = ^{pfx_i[PFX_TYPE_LSB-1:PFX_K_BIT+1],
                             pfx_i[PFX_K_BIT-1:PFX_SID_W]};

  always_comb begin
    fld_o.match = pfx_vld_i && (pfx_i[PFX_TYPE_LSB +: 8] == PFX_TYPE);
    fld_o.sid   = pfx_i[PFX_SID_W-1:0];
    fld_o.k     = pfx_i[PFX_K_BIT];
  end
endmodule

// File: rtl/lsc_stream.sv
module lsc_stream
  import lsc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_we_i,
  input  logic       ctrl_en_i,
  input  logic       key_ld_i,
  input  logic       key_slot_i,
  input  logic       ksw_i,
  input  logic       pfx_err_i,
  output logic       arm_err_o,
  output logic       secure_o,
  output logic       act_o,
  output logic [1:0] vld_o
);
  sec_st_e    st_q, st_d;
  logic       en_q;
  logic       act_q, act_d;
  logic [1:0] vld_q, vld_d;
  logic       sec, arm, dis, drop, ksw_ok;

  assign sec    = (st_q == ST_SEC);
  assign arm    = ctrl_we_i && ctrl_en_i && !sec;
  assign dis    = ctrl_we_i && !ctrl_en_i;
  assign drop   = sec && (dis || pfx_err_i);
  // active index is 0 whenever insecure, so arming looks at slot 0 only
  assign arm_err_o = arm && !vld_q[0];
  assign ksw_ok = sec && ksw_i && vld_q[!act_q] && !drop;

  always_comb begin
    st_d  = st_q;
    act_d = act_q;
    vld_d = vld_q;
    if (key_ld_i) vld_d[key_slot_i] = 1'b1;
    if (drop) begin
      st_d  = ST_INSEC;
      act_d = 1'b0;
      vld_d = 2'b00;
    end else if (arm && vld_q[0]) begin
      st_d = ST_SEC;
    end else if (ksw_ok) begin
      act_d        = !act_q;
      vld_d[act_q] = 1'b0;
    end
    if (dis) act_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_INSEC;
      en_q  <= 1'b0;
      act_q <= 1'b0;
      vld_q <= 2'b00;
    end else begin
      st_q  <= st_d;
      act_q <= act_d;
      vld_q <= vld_d;
      if (ctrl_we_i) en_q <= ctrl_en_i;
    end
  end

  assign secure_o = sec;
  assign act_o    = act_q;
  assign vld_o    = vld_q;

  AST_SEC_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec |-> en_q); // R3
  AST_ARM_NO_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm && !vld_q[0]) |=> !sec); // R4
  AST_INSEC_ACT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec |-> !act_q); // R5
  AST_LOSS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sec) |-> (vld_q == 2'b00)); // R9
  AST_SWITCH_RETIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ksw_ok |=> !vld_q[$past(act_q)]); // R6
  AST_SWITCH_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ksw_i && !sec && !ctrl_we_i) |=> !sec); // R7
endmodule

// File: rtl/link_sec_ctrl.sv
module link_sec_ctrl
  import lsc_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  localparam int SID_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ctrl_we_i,
  input  logic [SID_W-1:0]       ctrl_sid_i,
  input  logic [CTRL_W-1:0]      ctrl_wdata_i,
  input  logic                   key_ld_i,
  input  logic [SID_W-1:0]       key_sid_i,
  input  logic                   key_slot_i,
  input  logic                   ksw_i,
  input  logic [SID_W-1:0]       ksw_sid_i,
  input  logic                   pfx_vld_i,
  input  logic [PFX_W-1:0]       pfx_i,
  output logic                   pfx_hit_o,
  output logic [SID_W-1:0]       pfx_sid_o,
  output logic                   pfx_key_o,
  output logic                   err_o,
  output logic [NUM_STREAMS-1:0] secure_o,
  output logic [NUM_STREAMS-1:0] key_act_o,
  output logic [NUM_STREAMS-1:0] key_vld0_o,
  output logic [NUM_STREAMS-1:0] key_vld1_o
);
  pfx_fields_t            fld;
  logic                   in_range, key_ok, pfx_err, pfx_hit;
  logic [SID_W-1:0]       sid_idx;
  logic [NUM_STREAMS-1:0] arm_err;
  logic                   hit_q, key_q, err_q;
  logic [SID_W-1:0]       sid_q;
  logic                   unused_ctrl_bits;

  assign unused_ctrl_bits = ^ctrl_wdata_i[CTRL_W-1:1];

  lsc_pfx_dec u_dec (
    .pfx_vld_i (pfx_vld_i),
    .pfx_i     (pfx_i),
    .fld_o     (fld)
  );

  assign in_range = int'(fld.sid) < NUM_STREAMS;
  assign sid_idx  = fld.sid[SID_W-1:0];
  assign key_ok   = fld.k ? key_vld1_o[sid_idx] : key_vld0_o[sid_idx];
  assign pfx_err  = fld.match && (!in_range || !secure_o[sid_idx] || !key_ok);
  assign pfx_hit  = fld.match && !pfx_err;

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_stream
    logic [1:0] vld;
    lsc_stream u_stream (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctrl_we_i  (ctrl_we_i && (ctrl_sid_i == SID_W'(i))),
      .ctrl_en_i  (ctrl_wdata_i[0]),
      .key_ld_i   (key_ld_i && (key_sid_i == SID_W'(i))),
      .key_slot_i (key_slot_i),
      .ksw_i      (ksw_i && (ksw_sid_i == SID_W'(i))),
      .pfx_err_i  (pfx_err && in_range && (sid_idx == SID_W'(i))),
      .arm_err_o  (arm_err[i]),
      .secure_o   (secure_o[i]),
      .act_o      (key_act_o[i]),
      .vld_o      (vld)
    );
    assign key_vld0_o[i] = vld[0];
    assign key_vld1_o[i] = vld[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      sid_q <= '0;
      key_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      hit_q <= pfx_hit;
      sid_q <= sid_idx;
      key_q <= fld.k;
      err_q <= pfx_err || (|arm_err);
    end
  end

  assign pfx_hit_o = hit_q;
  assign pfx_sid_o = sid_q;
  assign pfx_key_o = key_q;
  assign err_o     = err_q;

  AST_FOREIGN_PFX_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pfx_vld_i && pfx_i[PFX_TYPE_LSB +: 8] != PFX_TYPE) |=> !pfx_hit_o); // R10
  AST_OOR_SID_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fld.match && !in_range) |=> (err_o && !pfx_hit_o)); // R9
  AST_HIT_HAS_ERR_FREE_PFX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fld.match && secure_o[sid_idx] && in_range && key_ok) |=> pfx_hit_o); // R8
endmodule

// File: tb/tb_link_sec_ctrl.sv
`timescale 1ns/1ps
module tb_link_sec_ctrl;
  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrl_we = 0, key_ld = 0, key_slot = 0, ksw = 0, pfx_vld = 0;
  logic [2:0]    ctrl_sid = 0, key_sid = 0, ksw_sid = 0;
  logic [7:0]    ctrl_wdata = 0;
  logic [31:0]   pfx = 0;
  logic          pfx_hit, pfx_key, err;
  logic [2:0]    pfx_sid;
  logic [NS-1:0] secure, key_act, vld0, vld1;

  int total = 0, bad = 0;
  bit msec [NS], mact [NS], mv0 [NS], mv1 [NS];
  bit e_err, e_hit, e_key;
  int e_sid;

  always #5 clk = ~clk;

  link_sec_ctrl #(.NUM_STREAMS(NS)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_sid_i(ctrl_sid), .ctrl_wdata_i(ctrl_wdata),
    .key_ld_i(key_ld), .key_sid_i(key_sid), .key_slot_i(key_slot),
    .ksw_i(ksw), .ksw_sid_i(ksw_sid),
    .pfx_vld_i(pfx_vld), .pfx_i(pfx),
    .pfx_hit_o(pfx_hit), .pfx_sid_o(pfx_sid), .pfx_key_o(pfx_key), .err_o(err),
    .secure_o(secure), .key_act_o(key_act), .key_vld0_o(vld0), .key_vld1_o(vld1)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp(string req);
    chk({req, " err"}, int'(err), int'(e_err));
    chk({req, " hit"}, int'(pfx_hit), int'(e_hit));
    if (e_hit) begin
      chk({req, " sid"}, int'(pfx_sid), e_sid);
      chk({req, " key"}, int'(pfx_key), int'(e_key));
    end
    for (int s = 0; s < NS; s++)
      chk($sformatf("%s stream%0d", req, s),
          int'({secure[s], key_act[s], vld0[s], vld1[s]}),
          int'({msec[s], mact[s], mv0[s], mv1[s]}));
  endtask

  task automatic finish_op(string req);
    @(posedge clk); #1;
    ctrl_we = 0; key_ld = 0; ksw = 0; pfx_vld = 0;
    cmp(req);
  endtask

  task automatic drop_model(int s);
    msec[s] = 0; mact[s] = 0; mv0[s] = 0; mv1[s] = 0;
  endtask

  task automatic op_ctrl(int s, bit en, string req);
    @(negedge clk);
    e_err = 0; e_hit = 0;
    ctrl_we = 1; ctrl_sid = 3'(s);
    ctrl_wdata = en ? 8'hA5 : 8'hFE; // R3: upper bits vary, only bit 0 counts
    if (en) begin
      if (!msec[s]) begin
        if (mv0[s]) msec[s] = 1; else e_err = 1;
      end
    end else begin
      if (msec[s]) drop_model(s);
      mact[s] = 0;
    end
    finish_op(req);
  endtask

  task automatic op_load(int s, bit slot, string req);
    @(negedge clk);
    e_err = 0; e_hit = 0;
    key_ld = 1; key_sid = 3'(s); key_slot = slot;
    if (slot) mv1[s] = 1; else mv0[s] = 1;
    finish_op(req);
  endtask

  task automatic op_ksw(int s, string req);
    @(negedge clk);
    e_err = 0; e_hit = 0;
    ksw = 1; ksw_sid = 3'(s);
    if (msec[s] && (mact[s] ? mv0[s] : mv1[s])) begin
      if (mact[s]) mv1[s] = 0; else mv0[s] = 0;
      mact[s] = !mact[s];
    end
    finish_op(req);
  endtask

  task automatic op_pfx(logic [7:0] typ, int sid, bit k, string req);
    @(negedge clk);
    e_err = 0; e_hit = 0;
    pfx_vld = 1;
    pfx = {typ, 8'h5a, 2'b01, k, 5'h0a, 8'(sid)};
    if (typ == 8'h92) begin
      if (sid >= NS) e_err = 1;
      else if (!msec[sid]) e_err = 1;
      else if (!(k ? mv1[sid] : mv0[sid])) begin
        e_err = 1; drop_model(sid);
      end else begin
        e_hit = 1; e_sid = sid; e_key = k;
      end
    end
    finish_op(req);
  endtask

  task automatic idle(string req);
    @(negedge clk);
    e_err = 0; e_hit = 0;
    finish_op(req);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) drop_model(s);
    e_err = 0; e_hit = 0;
    #22 rst_n = 1;
    @(negedge clk);
    cmp("R1 reset");
    for (int s = 0; s < NS; s++) begin
      op_ctrl(s, 1, "R4 arm without key");
      idle("R11 err drops");
      op_load(s, 0, "R2 load slot0");
      op_ctrl(s, 1, "R3 arm with key");
      op_ksw(s, "R7 switch to invalid set");
      op_pfx(8'h92, s, 0, "R8 hit k0");
      op_load(s, 1, "R2 load slot1");
      op_ksw(s, "R6 switch to set1");
      op_pfx(8'h92, s, 1, "R8 hit k1");
      op_pfx(8'h92, s, 0, "R9 retired set");
      idle("R11 err drops");
      op_ksw(s, "R7 switch while insecure");
      op_pfx(8'h92, s, 1, "R9 insecure stream");
      op_load(s, 0, "R2 reload slot0");
      op_ctrl(s, 1, "R3 rearm");
      op_pfx(8'h93, s, 1, "R10 foreign type");
      op_pfx(8'h12, s, 0, "R10 foreign type");
      op_load(s, 1, "R2 reload slot1");
      op_ksw(s, "R6 switch to set1");
      op_load(s, 0, "R2 reload slot0");
      op_ksw(s, "R6 switch back to set0");
      op_pfx(8'h92, s, 0, "R8 hit after return");
      if (s % 2 == 0) op_ctrl(s, 0, "R5 disable secure");
      else op_pfx(8'h92, s, 1, "R9 retired set1");
      op_ctrl(s, 0, "R5 disable insecure");
    end
    // leave a few streams secure and sweep prefixes over the whole ID field
    for (int s = 0; s < NS; s += 3) begin
      op_load(s, 0, "R2 load");
      op_ctrl(s, 1, "R3 arm");
    end
    for (int sid = 0; sid < 256; sid++)
      for (int k = 0; k < 2; k++)
        op_pfx(8'h92, sid, k[0], sid >= NS ? "R9 id sweep" : "R8 id sweep");
    idle("R11 quiet");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule